// File: doc/BRIEF.md
# Cascadable Latched Serial-to-Parallel Switch Driver

This block turns a serial bit stream into eight parallel switch controls. Bits enter one at a time on the rising edge of a shift clock and move down a chain of eight stages. A second, independent register clock copies all stages at once into a storage register, so the outputs change only when a whole new pattern is ready. Each output bit is a "sink enabled" control for one low-side open-drain switch: a 1 turns the switch on and a 0 turns it off.

An active-low clear empties the shift chain asynchronously and leaves the storage register and the outputs alone. An active-high output disable forces every switch off at once, with no clocking in that path. The last shift stage leaves the block as a serial output, so a second device fed from it forms a longer chain that all devices load on one shared register-clock pulse.

Top module: `cascade_sink_driver`

## Requirements
- R1: On each rising edge of shiftClk, while clearN is high, stage 0 takes serIn and stage i takes the old value of stage i-1, for i from 1 to 7.
- R2: On each rising edge of latchClk, the storage register takes all eight shift stages in parallel, with stage i going to storage bit i. If latchClk and shiftClk rise at the same instant, the storage register takes the stage values from before that shift.
- R3: While clearN is low, the shift stages are held at zero without waiting for a clock edge, and shiftClk edges have no effect. The clear does not change the storage register or sinkEn.
- R4: While outDisable is high, every bit of sinkEn is 0, with no clock edge needed.
- R5: While outDisable is low, sinkEn[i] equals storage bit i, where 1 means the switch sinks current and 0 means it is off.
- R6: serOut always equals shift stage 7, so a bit shifted in appears on serOut after eight shift edges and then leaves it in the order it was shifted in.
- R7: With a second device's serIn fed from the first device's serOut, sixteen shifts followed by one register-clock pulse place the bit shifted k-th (k = 0 first) at chain position 15-k. Positions 0 to 7 are the first device's sinkEn bits, and positions 8 to 15 are the second device's sinkEn bits 0 to 7.
- R8: Between rising edges of latchClk, the storage register and sinkEn hold their values while the shift stages keep changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Shift clock; the stages advance on its rising edge |
| latchClk | input | 1 | Register clock; the storage register captures on its rising edge |
| clearN | input | 1 | Active-low asynchronous clear of the shift stages only |
| outDisable | input | 1 | Active-high force of all switches to off |
| serIn | input | 1 | Serial data into stage 0 |
| serOut | output | 1 | Stage 7, for feeding a following device |
| sinkEn | output | 8 | Switch controls, 1 = sink on |

## Verification
A wrong shift stage first shows on serOut after the remaining shift edges bring it to stage 7. It shows on sinkEn only after the next register-clock pulse, unless outDisable is high, in which case sinkEn hides it completely. A storage fault shows on sinkEn at once while outDisable is low, and it stays there until the next capture. A clear that wrongly reaches the storage register shows on sinkEn within the same cycle. The two-device chain exposes a misordered serial output, because the bits then land in the wrong positions of the second device.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;
  typedef struct packed {
    logic clearShift;
    logic forceOff;
  } drvStrobes_t;
endpackage

// File: rtl/sink_drv_ctrl.sv
module sink_drv_ctrl
  import sink_drv_pkg::*;
(
  input  logic        clearN,
  input  logic        outDisable,
  output drvStrobes_t strobes
);
  always_comb begin
    strobes.clearShift = ~clearN;
    strobes.forceOff   = outDisable;
  end
endmodule

// File: rtl/sink_drv_datapath.sv
module sink_drv_datapath
  import sink_drv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  drvStrobes_t      strobes,
  input  logic             serIn,
  output logic [WIDTH-1:0] shiftState,
  output logic [WIDTH-1:0] storeState,
  output logic             serOut,
  output logic [WIDTH-1:0] sinkEn
);
  localparam int LAST = WIDTH - 1;

  logic clearShift;
  logic forceOff;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;

  assign clearShift = strobes.clearShift;
  assign forceOff   = strobes.forceOff;

  // Stage 0 is fed from serIn; each higher stage is fed from the one below it.
  generate
    for (genvar s = 0; s < WIDTH; s++) begin : g_stage
      logic stageIn;
      if (s == 0) begin : g_head
        assign stageIn = serIn;
      end else begin : g_body
        assign stageIn = shiftQ[s-1];
      end
      always_ff @(posedge shiftClk or posedge clearShift) begin
        if (clearShift) shiftQ[s] <= 1'b0;
        else            shiftQ[s] <= stageIn;
      end
    end
  endgenerate

  // The storage register has no reset; the clear deliberately does not reach it.
  always_ff @(posedge latchClk) begin
    storeQ <= shiftQ;
  end

  // The output gate is combinational: the disable acts without any clock.
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_gate
      assign sinkEn[b] = storeQ[b] & ~forceOff;
    end
  endgenerate

  assign serOut     = shiftQ[LAST];
  assign shiftState = shiftQ;
  assign storeState = storeQ;
endmodule

// File: rtl/cascade_sink_driver.sv
module cascade_sink_driver
  import sink_drv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             clearN,
  input  logic             outDisable,
  input  logic             serIn,
  output logic             serOut,
  output logic [WIDTH-1:0] sinkEn
);
  drvStrobes_t      strobes;
  logic [WIDTH-1:0] shiftState;
  logic [WIDTH-1:0] storeState;

  sink_drv_ctrl u_ctrl (
    .clearN     (clearN),
    .outDisable (outDisable),
    .strobes    (strobes)
  );

  sink_drv_datapath #(.WIDTH(WIDTH)) u_dp (
    .shiftClk   (shiftClk),
    .latchClk   (latchClk),
    .strobes    (strobes),
    .serIn      (serIn),
    .shiftState (shiftState),
    .storeState (storeState),
    .serOut     (serOut),
    .sinkEn     (sinkEn)
  );
endmodule

// File: rtl/sink_drv_checker.sv
module sink_drv_checker #(
  parameter int WIDTH = 8
) (
  input logic             shiftClk,
  input logic             latchClk,
  input logic             clearN,
  input logic             outDisable,
  input logic             serIn,
  input logic             serOut,
  input logic [WIDTH-1:0] sinkEn,
  input logic [WIDTH-1:0] shiftState,
  input logic [WIDTH-1:0] storeState
);
  // Set when a clear has occurred since the previous shift edge.
  logic clrSeen = 1'b1;
  // Set once the storage register has captured at least once.
  logic latchSeen = 1'b0;

  always_ff @(posedge shiftClk or negedge clearN) begin
    if (!clearN) clrSeen <= 1'b1;
    else         clrSeen <= 1'b0;
  end

  always_ff @(posedge latchClk) begin
    latchSeen <= 1'b1;
  end

  // R1: each stage advances by one per shift edge
  a_r1_shift_step: assert property (@(posedge shiftClk) disable iff (!clearN)
    !clrSeen |-> (shiftState[WIDTH-1:1] == $past(shiftState[WIDTH-2:0]))
                 && (shiftState[0] == $past(serIn)));

  // R2: storage equals the stage values seen at the previous capture edge
  a_r2_parallel_capture: assert property (@(posedge latchClk) disable iff (!clearN)
    latchSeen |-> storeState == $past(shiftState));

  // R3: a capture while clear is low finds an empty shift chain
  a_r3_clear_empties: assert property (@(posedge latchClk)
    !clearN |-> shiftState == '0);

  // R4: disabled outputs are all off
  a_r4_force_off: assert property (@(posedge latchClk) disable iff (!clearN)
    outDisable |-> sinkEn == '0);

  // R6: serial output moves on from stage 6 of the previous edge
  a_r6_serial_tail: assert property (@(posedge shiftClk) disable iff (!clearN)
    !clrSeen |-> serOut == $past(shiftState[WIDTH-2]));
endmodule

bind cascade_sink_driver sink_drv_checker #(.WIDTH(WIDTH)) u_chk (
  .shiftClk   (shiftClk),
  .latchClk   (latchClk),
  .clearN     (clearN),
  .outDisable (outDisable),
  .serIn      (serIn),
  .serOut     (serOut),
  .sinkEn     (sinkEn),
  .shiftState (shiftState),
  .storeState (storeState)
);

// File: tb/tb_cascade_sink_driver.sv
`timescale 1ns/1ps
module tb_cascade_sink_driver;
  logic clk = 1'b0;
  logic latchClk = 1'b0;
  logic clearN = 1'b0;
  logic outDisable = 1'b1;
  logic serIn = 1'b0;
  logic serOut, serOutB;
  logic [7:0] sinkEn, sinkEnB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cascade_sink_driver dut (
    .shiftClk(clk), .latchClk(latchClk), .clearN(clearN),
    .outDisable(outDisable), .serIn(serIn), .serOut(serOut), .sinkEn(sinkEn));

  cascade_sink_driver dut2 (
    .shiftClk(clk), .latchClk(latchClk), .clearN(clearN),
    .outDisable(outDisable), .serIn(serOut), .serOut(serOutB), .sinkEn(sinkEnB));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk);
    serIn = b;
    @(posedge clk);
    #1;
  endtask

  // Shifts bit 7 first so that stage i ends up holding v[i].
  task automatic shiftByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shiftBit(v[i]);
  endtask

  task automatic pulseLatch();
    @(negedge clk);
    #2 latchClk = 1'b1;
    #4 latchClk = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    #5;
    check("R4 disabled at start", {24'h0, sinkEn}, 32'h0);
    check("R3 serOut empty under clear", {31'h0, serOut}, 32'h0);
    pulseLatch();
    outDisable = 1'b0;
    #1;
    check("R3 storage of cleared chain", {24'h0, sinkEn}, 32'h0);
    clearN = 1'b1;
  endtask

  task automatic t_shiftLatch(input logic [7:0] v);
    shiftByte(v);
    pulseLatch();
    check("R1 R2 R5 parallel load", {24'h0, sinkEn}, {24'h0, v});
  endtask

  task automatic t_serialTail(input logic [7:0] v);
    shiftByte(v);
    for (int i = 7; i >= 0; i--) begin
      check("R6 serOut order", {31'h0, serOut}, {31'h0, v[i]});
      shiftBit(1'b0);
    end
  endtask

  task automatic t_hold();
    shiftByte(8'h5A);
    pulseLatch();
    shiftByte(8'hFF);
    check("R8 storage holds while shifting", {24'h0, sinkEn}, 32'h5A);
    shiftByte(8'h00);
    check("R8 storage still held", {24'h0, sinkEn}, 32'h5A);
  endtask

  task automatic t_disable();
    shiftByte(8'hC3);
    pulseLatch();
    #3 outDisable = 1'b1;
    #1;
    check("R4 force off without clock", {24'h0, sinkEn}, 32'h0);
    #1 outDisable = 1'b0;
    #1;
    check("R5 restore after disable", {24'h0, sinkEn}, 32'hC3);
  endtask

  task automatic t_clear();
    shiftByte(8'h96);
    pulseLatch();
    shiftByte(8'hFF);
    @(posedge clk);
    #3 clearN = 1'b0;
    #1;
    check("R3 clear empties chain", {31'h0, serOut}, 32'h0);
    check("R3 clear leaves outputs", {24'h0, sinkEn}, 32'h96);
    serIn = 1'b1;
    @(posedge clk);
    #1;
    check("R3 clear overrides shift clock", {31'h0, serOut}, 32'h0);
    serIn = 1'b0;
    @(negedge clk);
    clearN = 1'b1;
    #2;
    check("R3 storage untouched after clear", {24'h0, sinkEn}, 32'h96);
    pulseLatch();
    check("R3 chain was emptied", {24'h0, sinkEn}, 32'h0);
  endtask

  task automatic t_sameEdge();
    shiftByte(8'h0F);
    @(negedge clk);
    serIn = 1'b1;
    @(posedge clk);
    latchClk = 1'b1;
    #3 latchClk = 1'b0;
    #2;
    check("R2 same-edge takes pre-shift", {24'h0, sinkEn}, 32'h0F);
    pulseLatch();
    check("R2 next capture takes shifted", {24'h0, sinkEn}, 32'h1F);
  endtask

  task automatic t_cascade(input logic [15:0] w);
    for (int k = 0; k < 16; k++) shiftBit(w[15-k]);
    pulseLatch();
    check("R7 chain low device", {24'h0, sinkEn}, {24'h0, w[7:0]});
    check("R7 chain high device", {24'h0, sinkEnB}, {24'h0, w[15:8]});
    check("R6 second device tail", {31'h0, serOutB}, {31'h0, w[15]});
  endtask

  initial begin
    t_reset();
    t_shiftLatch(8'hA5);
    t_shiftLatch(8'h3C);
    t_serialTail(8'hB2);
    t_hold();
    t_disable();
    t_clear();
    t_sameEdge();
    t_cascade(16'hC3A5);
    t_cascade(16'h1E87);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule